// File: doc/BRIEF.md
# Exception State Save/Restore Unit

This unit keeps the three state flags that decide how a processor core reacts to an interrupt. The external-interrupt enable gates asynchronous requests. The machine-check enable gates hardware-error traps. The recoverable flag tells a handler whether the interrupted context can still be resumed. The unit also holds two save registers. One takes the return address when an exception is taken, and the other takes a snapshot of the flags at that moment.

The core drives an entry strobe with a cause code and return address, a return-from-interrupt strobe, a full state-word write, and a numbered special-register read/write port. Three special-register numbers act as write-only shortcuts: each one loads the interrupt enable and the recoverable flag with a fixed pair of values in a single write. Reading any of these three numbers is illegal. Such a read raises a one-cycle software-emulation request and changes no state. Two further numbers let a handler reload the save registers before it returns.

All updates are registered and appear after the next rising clock edge. When several requests arrive in the same cycle, a fixed priority resolves them.

Top module: `exc_state_unit`

## Requirements
- R1: While reset is asserted, every enable, the recoverable flag, both save registers and the emulation request are 0.
- R2: On an entry strobe, the save-address register takes the return address. The save-state register takes a word that holds the current external enable at bit 15, the machine-check enable at bit 12 and the recoverable flag at bit 1, with all other bits 0. The recoverable flag becomes 0. All of this is visible after the next edge.
- R3: On entry, cause code 0 (system reset) and code 1 (machine check) clear the machine-check enable. Code 2 (external) and code 3 (decrementer) clear the external enable. Codes 4 to 7 leave both enables unchanged.
- R4: A return-from-interrupt loads the external enable, the machine-check enable and the recoverable flag from bits 15, 12 and 1 of the save-state register. Both save registers are left unchanged.
- R5: A state-word write loads the three flags from bits 15, 12 and 1 of the written word, and any value is allowed. The other bits are ignored.
- R6: A write to special register 80 sets the external enable to 1 and the recoverable flag to 1. The machine-check enable is unchanged.
- R7: A write to special register 81 sets the external enable to 0 and the recoverable flag to 1.
- R8: A write to special register 82 sets both the external enable and the recoverable flag to 0.
- R9: A write to special register 26 loads the full word into the save-address register. A write to special register 27 loads the full word into the save-state register.
- R10: A read of special register 80, 81 or 82 raises the emulation request for exactly the following cycle and changes no flag or save register. Reads of other numbers raise no request.
- R11: Entry takes priority over everything else in the same cycle: return, state-word write and special-register write are discarded, and an illegal read raises no request. A return takes priority over both kinds of write. A state-word write takes priority over a special-register write.
- R12: A special-register write to any number other than 26, 27, 80, 81 or 82 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_take_i | input | 1 | Exception entry strobe |
| exc_kind_i | input | 3 | Cause code of the exception being taken |
| exc_pc_i | input | 32 | Return address to save on entry |
| rfi_i | input | 1 | Return-from-interrupt strobe |
| st_we_i | input | 1 | Full state-word write strobe |
| st_wdata_i | input | 32 | State word to write |
| spr_we_i | input | 1 | Special-register write strobe |
| spr_re_i | input | 1 | Special-register read strobe |
| spr_num_i | input | 10 | Special-register number |
| spr_wdata_i | input | 32 | Special-register write data |
| ext_en_o | output | 1 | External interrupt enable |
| mchk_en_o | output | 1 | Machine-check enable |
| recov_o | output | 1 | Recoverable flag |
| save_pc_o | output | 32 | Saved return address |
| save_st_o | output | 32 | Saved state word |
| emu_trap_o | output | 1 | Software-emulation request for an illegal read |

## Verification
Exception entry and a flag write can land in the same cycle. The write may come through a shortcut special register or through the full state word. The bench drives an entry strobe together with a write to register 80, which would set the recoverable flag, and checks that the flag still reads 0 and that the snapshot holds the pre-entry flags. The bench also pairs a return with a state-word write, a state-word write with a write to register 82, and an entry with an illegal read. In each case it predicts from the priority rule which request wins, and it compares the flags, save registers and emulation request one edge later.

// File: rtl/exc_state_pkg.sv
package exc_state_pkg;

    typedef enum logic [2:0] {
        EXC_SYSRST = 3'd0,
        EXC_MCHK   = 3'd1,
        EXC_EXTINT = 3'd2,
        EXC_DECR   = 3'd3,
        EXC_OTHER4 = 3'd4,
        EXC_OTHER5 = 3'd5,
        EXC_OTHER6 = 3'd6,
        EXC_OTHER7 = 3'd7
    } exc_kind_e;

    typedef enum logic [2:0] {
        SPR_OP_NONE,
        SPR_OP_EN_ALL,
        SPR_OP_DIS_EXT,
        SPR_OP_NONRECOV,
        SPR_OP_SAVE_PC,
        SPR_OP_SAVE_ST
    } spr_op_e;

endpackage

// File: rtl/exc_kind_mask.sv
module exc_kind_mask
    import exc_state_pkg::*;
(
    input  exc_kind_e kind_i,
    output logic      clr_ext_o,
    output logic      clr_mchk_o
);

    always_comb begin
        clr_ext_o  = 1'b0;
        clr_mchk_o = 1'b0;
        unique case (kind_i)
            EXC_SYSRST, EXC_MCHK:  clr_mchk_o = 1'b1;
            EXC_EXTINT, EXC_DECR:  clr_ext_o  = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/exc_spr_decode.sv
module exc_spr_decode
    import exc_state_pkg::*;
#(
    parameter int SPR_W        = 10,
    parameter int SPR_EN_ALL   = 80,
    parameter int SPR_DIS_EXT  = 81,
    parameter int SPR_NONRECOV = 82,
    parameter int SPR_SAVE_PC  = 26,
    parameter int SPR_SAVE_ST  = 27
) (
    input  logic             we_i,
    input  logic             re_i,
    input  logic [SPR_W-1:0] num_i,
    output spr_op_e          op_o,
    output logic             rd_trap_o
);

    localparam logic [SPR_W-1:0] N_EN_ALL   = SPR_W'(SPR_EN_ALL);
    localparam logic [SPR_W-1:0] N_DIS_EXT  = SPR_W'(SPR_DIS_EXT);
    localparam logic [SPR_W-1:0] N_NONRECOV = SPR_W'(SPR_NONRECOV);
    localparam logic [SPR_W-1:0] N_SAVE_PC  = SPR_W'(SPR_SAVE_PC);
    localparam logic [SPR_W-1:0] N_SAVE_ST  = SPR_W'(SPR_SAVE_ST);

    logic is_shortcut;

    always_comb begin
        is_shortcut = (num_i == N_EN_ALL) || (num_i == N_DIS_EXT) ||
                      (num_i == N_NONRECOV);
        rd_trap_o   = re_i && is_shortcut;

        op_o = SPR_OP_NONE;
        if (we_i) begin
            if (num_i == N_EN_ALL)        op_o = SPR_OP_EN_ALL;
            else if (num_i == N_DIS_EXT)  op_o = SPR_OP_DIS_EXT;
            else if (num_i == N_NONRECOV) op_o = SPR_OP_NONRECOV;
            else if (num_i == N_SAVE_PC)  op_o = SPR_OP_SAVE_PC;
            else if (num_i == N_SAVE_ST)  op_o = SPR_OP_SAVE_ST;
        end
    end

endmodule

// File: rtl/exc_bit_pack.sv
module exc_bit_pack #(
    parameter int XLEN     = 32,
    parameter int EXT_POS  = 15,
    parameter int MCHK_POS = 12,
    parameter int REC_POS  = 1
) (
    input  logic            ext_i,
    input  logic            mchk_i,
    input  logic            rec_i,
    output logic [XLEN-1:0] word_o
);

    always_comb begin
        word_o           = '0;
        word_o[EXT_POS]  = ext_i;
        word_o[MCHK_POS] = mchk_i;
        word_o[REC_POS]  = rec_i;
    end

endmodule

// File: rtl/exc_bit_unpack.sv
module exc_bit_unpack #(
    parameter int XLEN     = 32,
    parameter int EXT_POS  = 15,
    parameter int MCHK_POS = 12,
    parameter int REC_POS  = 1
) (
    input  logic [XLEN-1:0] word_i,
    output logic            ext_o,
    output logic            mchk_o,
    output logic            rec_o
);

    logic unused_bits;

    assign ext_o       = word_i[EXT_POS];
    assign mchk_o      = word_i[MCHK_POS];
    assign rec_o       = word_i[REC_POS];
    assign unused_bits = ^word_i;

endmodule

// File: rtl/exc_state_unit.sv
module exc_state_unit
    import exc_state_pkg::*;
#(
    parameter int XLEN         = 32,
    parameter int SPR_W        = 10,
    parameter int EXT_POS      = 15,
    parameter int MCHK_POS     = 12,
    parameter int REC_POS      = 1,
    parameter int SPR_EN_ALL   = 80,
    parameter int SPR_DIS_EXT  = 81,
    parameter int SPR_NONRECOV = 82,
    parameter int SPR_SAVE_PC  = 26,
    parameter int SPR_SAVE_ST  = 27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exc_take_i,
    input  logic [2:0]       exc_kind_i,
    input  logic [XLEN-1:0]  exc_pc_i,
    input  logic             rfi_i,
    input  logic             st_we_i,
    input  logic [XLEN-1:0]  st_wdata_i,
    input  logic             spr_we_i,
    input  logic             spr_re_i,
    input  logic [SPR_W-1:0] spr_num_i,
    input  logic [XLEN-1:0]  spr_wdata_i,
    output logic             ext_en_o,
    output logic             mchk_en_o,
    output logic             recov_o,
    output logic [XLEN-1:0]  save_pc_o,
    output logic [XLEN-1:0]  save_st_o,
    output logic             emu_trap_o
);

    typedef struct packed {
        logic [XLEN-1:0] save_pc;
        logic [XLEN-1:0] save_st;
        logic            ext_en;
        logic            mchk_en;
        logic            recov;
        logic            emu_trap;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic            clr_ext, clr_mchk;
    spr_op_e         spr_op;
    logic            rd_trap;
    logic [XLEN-1:0] snap_word;
    logic            sv_ext, sv_mchk, sv_rec;
    logic            wr_ext, wr_mchk, wr_rec;

    exc_kind_mask u_kind (
        .kind_i     (exc_kind_e'(exc_kind_i)),
        .clr_ext_o  (clr_ext),
        .clr_mchk_o (clr_mchk)
    );

    exc_spr_decode #(
        .SPR_W        (SPR_W),
        .SPR_EN_ALL   (SPR_EN_ALL),
        .SPR_DIS_EXT  (SPR_DIS_EXT),
        .SPR_NONRECOV (SPR_NONRECOV),
        .SPR_SAVE_PC  (SPR_SAVE_PC),
        .SPR_SAVE_ST  (SPR_SAVE_ST)
    ) u_spr (
        .we_i      (spr_we_i),
        .re_i      (spr_re_i),
        .num_i     (spr_num_i),
        .op_o      (spr_op),
        .rd_trap_o (rd_trap)
    );

    exc_bit_pack #(
        .XLEN(XLEN), .EXT_POS(EXT_POS), .MCHK_POS(MCHK_POS), .REC_POS(REC_POS)
    ) u_snap (
        .ext_i  (st_q.ext_en),
        .mchk_i (st_q.mchk_en),
        .rec_i  (st_q.recov),
        .word_o (snap_word)
    );

    exc_bit_unpack #(
        .XLEN(XLEN), .EXT_POS(EXT_POS), .MCHK_POS(MCHK_POS), .REC_POS(REC_POS)
    ) u_restore (
        .word_i (st_q.save_st),
        .ext_o  (sv_ext),
        .mchk_o (sv_mchk),
        .rec_o  (sv_rec)
    );

    exc_bit_unpack #(
        .XLEN(XLEN), .EXT_POS(EXT_POS), .MCHK_POS(MCHK_POS), .REC_POS(REC_POS)
    ) u_stwr (
        .word_i (st_wdata_i),
        .ext_o  (wr_ext),
        .mchk_o (wr_mchk),
        .rec_o  (wr_rec)
    );

    // Next-state: entry > return > state-word write > special-register write
    always_comb begin
        st_d          = st_q;
        st_d.emu_trap = 1'b0;
        if (exc_take_i) begin
            st_d.save_pc = exc_pc_i;
            st_d.save_st = snap_word;
            st_d.recov   = 1'b0;
            if (clr_ext)  st_d.ext_en  = 1'b0;
            if (clr_mchk) st_d.mchk_en = 1'b0;
        end else begin
            st_d.emu_trap = rd_trap;
            if (rfi_i) begin
                st_d.ext_en  = sv_ext;
                st_d.mchk_en = sv_mchk;
                st_d.recov   = sv_rec;
            end else if (st_we_i) begin
                st_d.ext_en  = wr_ext;
                st_d.mchk_en = wr_mchk;
                st_d.recov   = wr_rec;
            end else begin
                unique case (spr_op)
                    SPR_OP_EN_ALL: begin
                        st_d.ext_en = 1'b1;
                        st_d.recov  = 1'b1;
                    end
                    SPR_OP_DIS_EXT: begin
                        st_d.ext_en = 1'b0;
                        st_d.recov  = 1'b1;
                    end
                    SPR_OP_NONRECOV: begin
                        st_d.ext_en = 1'b0;
                        st_d.recov  = 1'b0;
                    end
                    SPR_OP_SAVE_PC: st_d.save_pc = spr_wdata_i;
                    SPR_OP_SAVE_ST: st_d.save_st = spr_wdata_i;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ext_en_o   = st_q.ext_en;
    assign mchk_en_o  = st_q.mchk_en;
    assign recov_o    = st_q.recov;
    assign save_pc_o  = st_q.save_pc;
    assign save_st_o  = st_q.save_st;
    assign emu_trap_o = st_q.emu_trap;

endmodule

// File: rtl/exc_state_chk.sv
module exc_state_chk #(
    parameter int XLEN         = 32,
    parameter int SPR_W        = 10,
    parameter int EXT_POS      = 15,
    parameter int MCHK_POS     = 12,
    parameter int REC_POS      = 1,
    parameter int SPR_EN_ALL   = 80,
    parameter int SPR_DIS_EXT  = 81,
    parameter int SPR_NONRECOV = 82
) (
    input logic             clk,
    input logic             rst_n,
    input logic             exc_take_i,
    input logic [2:0]       exc_kind_i,
    input logic [XLEN-1:0]  exc_pc_i,
    input logic             rfi_i,
    input logic             st_we_i,
    input logic             spr_we_i,
    input logic             spr_re_i,
    input logic [SPR_W-1:0] spr_num_i,
    input logic             ext_en_o,
    input logic             mchk_en_o,
    input logic             recov_o,
    input logic [XLEN-1:0]  save_pc_o,
    input logic [XLEN-1:0]  save_st_o,
    input logic             emu_trap_o
);

    logic shortcut_num;
    assign shortcut_num = (spr_num_i == SPR_W'(SPR_EN_ALL)) ||
                          (spr_num_i == SPR_W'(SPR_DIS_EXT)) ||
                          (spr_num_i == SPR_W'(SPR_NONRECOV));

    // R2
    entry_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take_i |=> (save_pc_o == $past(exc_pc_i)) && !recov_o &&
                       (save_st_o[REC_POS] == $past(recov_o)) &&
                       (save_st_o[EXT_POS] == $past(ext_en_o)));

    // R3
    entry_mchk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_take_i && (exc_kind_i <= 3'd1)) |=> !mchk_en_o);

    // R4
    rfi_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi_i && !exc_take_i) |=> (recov_o == $past(save_st_o[REC_POS])) &&
                                   (ext_en_o == $past(save_st_o[EXT_POS])) &&
                                   (mchk_en_o == $past(save_st_o[MCHK_POS])) &&
                                   $stable(save_st_o) && $stable(save_pc_o));

    // R8
    nonrecov_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we_i && spr_num_i == SPR_W'(SPR_NONRECOV) && !exc_take_i && !rfi_i && !st_we_i)
            |=> !ext_en_o && !recov_o);

    // R10
    trap_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_re_i && shortcut_num && !exc_take_i) |=> emu_trap_o);

    // R10
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_re_i && !spr_we_i && !st_we_i && !rfi_i && !exc_take_i)
            |=> $stable(ext_en_o) && $stable(mchk_en_o) && $stable(recov_o) &&
                $stable(save_pc_o) && $stable(save_st_o));

    // R11
    trap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emu_trap_o |-> $past(spr_re_i) && !$past(exc_take_i));

endmodule

bind exc_state_unit exc_state_chk #(
    .XLEN(XLEN), .SPR_W(SPR_W), .EXT_POS(EXT_POS), .MCHK_POS(MCHK_POS),
    .REC_POS(REC_POS), .SPR_EN_ALL(SPR_EN_ALL), .SPR_DIS_EXT(SPR_DIS_EXT),
    .SPR_NONRECOV(SPR_NONRECOV)
) chk_i (
    .clk(clk), .rst_n(rst_n), .exc_take_i(exc_take_i), .exc_kind_i(exc_kind_i),
    .exc_pc_i(exc_pc_i), .rfi_i(rfi_i), .st_we_i(st_we_i), .spr_we_i(spr_we_i),
    .spr_re_i(spr_re_i), .spr_num_i(spr_num_i), .ext_en_o(ext_en_o),
    .mchk_en_o(mchk_en_o), .recov_o(recov_o), .save_pc_o(save_pc_o),
    .save_st_o(save_st_o), .emu_trap_o(emu_trap_o)
);

// File: tb/exc_state_unit_tb_top.sv
module exc_state_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_take_i;
    logic [2:0]  exc_kind_i;
    logic [31:0] exc_pc_i;
    logic        rfi_i;
    logic        st_we_i;
    logic [31:0] st_wdata_i;
    logic        spr_we_i;
    logic        spr_re_i;
    logic [9:0]  spr_num_i;
    logic [31:0] spr_wdata_i;
    logic        ext_en_o, mchk_en_o, recov_o, emu_trap_o;
    logic [31:0] save_pc_o, save_st_o;

    always #5 clk = ~clk;

    exc_state_unit dut_i (
        .clk(clk), .rst_n(rst_n), .exc_take_i(exc_take_i), .exc_kind_i(exc_kind_i),
        .exc_pc_i(exc_pc_i), .rfi_i(rfi_i), .st_we_i(st_we_i), .st_wdata_i(st_wdata_i),
        .spr_we_i(spr_we_i), .spr_re_i(spr_re_i), .spr_num_i(spr_num_i),
        .spr_wdata_i(spr_wdata_i), .ext_en_o(ext_en_o), .mchk_en_o(mchk_en_o),
        .recov_o(recov_o), .save_pc_o(save_pc_o), .save_st_o(save_st_o),
        .emu_trap_o(emu_trap_o)
    );

    typedef struct {
        logic        ext, mchk, rec, trap;
        logic [31:0] spc, sst;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // reference flags and save registers
    logic        m_ext, m_mchk, m_rec;
    logic [31:0] m_spc, m_sst;

    task automatic compare(input exp_t e);
        n_cmp++;
        if ({ext_en_o, mchk_en_o, recov_o, emu_trap_o, save_pc_o, save_st_o} !==
            {e.ext, e.mchk, e.rec, e.trap, e.spc, e.sst}) begin
            n_bad++;
            $display("FAIL %s: got ext=%b mchk=%b rec=%b trap=%b spc=%h sst=%h exp ext=%b mchk=%b rec=%b trap=%b spc=%h sst=%h",
                     e.tag, ext_en_o, mchk_en_o, recov_o, emu_trap_o, save_pc_o, save_st_o,
                     e.ext, e.mchk, e.rec, e.trap, e.spc, e.sst);
        end
    endtask

    function automatic logic [31:0] img(input logic x, input logic m, input logic r);
        logic [31:0] w;
        w = '0;
        w[15] = x;
        w[12] = m;
        w[1]  = r;
        return w;
    endfunction

    task automatic step(input logic exc, input logic [2:0] kind, input logic [31:0] pc,
                        input logic rfi, input logic stwe, input logic [31:0] stwd,
                        input logic swe, input logic sre, input logic [9:0] num,
                        input logic [31:0] swd, input string tag);
        exp_t e;
        logic trap;
        @(negedge clk);
        exc_take_i = exc; exc_kind_i = kind; exc_pc_i = pc; rfi_i = rfi;
        st_we_i = stwe; st_wdata_i = stwd; spr_we_i = swe; spr_re_i = sre;
        spr_num_i = num; spr_wdata_i = swd;
        trap = 1'b0;
        if (exc) begin
            m_sst = img(m_ext, m_mchk, m_rec);
            m_spc = pc;
            m_rec = 1'b0;
            if (kind == 3'd0 || kind == 3'd1) m_mchk = 1'b0;
            if (kind == 3'd2 || kind == 3'd3) m_ext  = 1'b0;
        end else begin
            trap = sre && (num == 10'd80 || num == 10'd81 || num == 10'd82);
            if (rfi) begin
                m_ext = m_sst[15]; m_mchk = m_sst[12]; m_rec = m_sst[1];
            end else if (stwe) begin
                m_ext = stwd[15]; m_mchk = stwd[12]; m_rec = stwd[1];
            end else if (swe) begin
                case (num)
                    10'd80: begin m_ext = 1'b1; m_rec = 1'b1; end
                    10'd81: begin m_ext = 1'b0; m_rec = 1'b1; end
                    10'd82: begin m_ext = 1'b0; m_rec = 1'b0; end
                    10'd26: m_spc = swd;
                    10'd27: m_sst = swd;
                    default: ;
                endcase
            end
        end
        e.ext = m_ext; e.mchk = m_mchk; e.rec = m_rec; e.trap = trap;
        e.spc = m_spc; e.sst = m_sst; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(0, 3'd0, 32'h0, 0, 0, 32'h0, 0, 0, 10'd0, 32'h0, tag);
    endtask

    // monitor: one edge after each driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n === 1'b1 && q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        exp_t r;
        rst_n = 1'b0;
        exc_take_i = 0; exc_kind_i = 0; exc_pc_i = 0; rfi_i = 0; st_we_i = 0;
        st_wdata_i = 0; spr_we_i = 0; spr_re_i = 0; spr_num_i = 0; spr_wdata_i = 0;
        m_ext = 0; m_mchk = 0; m_rec = 0; m_spc = 0; m_sst = 0;
        repeat (3) @(negedge clk);
        // R1 reset values
        r.ext = 0; r.mchk = 0; r.rec = 0; r.trap = 0; r.spc = 0; r.sst = 0; r.tag = "R1";
        compare(r);
        rst_n = 1'b1;

        // R5 state write, unrelated bits set and ignored
        step(0, 0, 0, 0, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R5 all ones");
        step(0, 0, 0, 0, 1, 32'h0000_9000, 0, 0, 0, 0, "R5 rec clear");
        step(0, 0, 0, 0, 1, 32'h0000_9002, 0, 0, 0, 0, "R5 set");
        // R2 entry with a neutral cause, R3 codes 4..7 keep enables
        step(1, 3'd4, 32'h0000_1000, 0, 0, 0, 0, 0, 0, 0, "R2 R3 entry kind4");
        // R6
        step(0, 0, 0, 0, 0, 0, 1, 0, 10'd80, 0, "R6 shortcut 80");
        // R4
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R4 return");
        // R3 external and system reset
        step(1, 3'd2, 32'h0000_2004, 0, 0, 0, 0, 0, 0, 0, "R3 external");
        step(0, 0, 0, 0, 0, 0, 1, 0, 10'd80, 0, "R6 reenable");
        step(1, 3'd0, 32'h0000_3008, 0, 0, 0, 0, 0, 0, 0, "R3 sysreset");
        // R7 R8
        step(0, 0, 0, 0, 0, 0, 1, 0, 10'd81, 0, "R7 shortcut 81");
        step(0, 0, 0, 0, 0, 0, 1, 0, 10'd82, 0, "R8 shortcut 82");
        // R10 illegal reads and a legal read
        step(0, 0, 0, 0, 0, 0, 0, 1, 10'd80, 0, "R10 read 80");
        step(0, 0, 0, 0, 0, 0, 0, 1, 10'd81, 0, "R10 read 81");
        step(0, 0, 0, 0, 0, 0, 0, 1, 10'd82, 0, "R10 read 82");
        idle("R10 trap one cycle");
        step(0, 0, 0, 0, 0, 0, 0, 1, 10'd26, 0, "R10 read 26");
        // R9
        step(0, 0, 0, 0, 0, 0, 1, 0, 10'd26, 32'hDEAD_BEE0, "R9 save pc");
        step(0, 0, 0, 0, 0, 0, 1, 0, 10'd27, 32'hA5A5_8002, "R9 save st");
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R4 return from written");
        // R12
        step(0, 0, 0, 0, 0, 0, 1, 0, 10'd100, 32'hFFFF_FFFF, "R12 other spr");
        step(0, 0, 0, 0, 0, 0, 1, 0, 10'd83, 32'hFFFF_FFFF, "R12 spr 83");
        // R11 priorities
        step(1, 3'd4, 32'h0000_4000, 1, 1, 32'hFFFF_FFFF, 1, 0, 10'd80, 0, "R11 entry over all");
        step(0, 0, 0, 0, 1, 32'h0000_9002, 1, 0, 10'd82, 0, "R11 state over spr");
        step(0, 0, 0, 1, 1, 32'h0000_9002, 0, 0, 0, 0, "R11 return over state");
        step(1, 3'd1, 32'h0000_5000, 0, 0, 0, 0, 1, 10'd81, 0, "R11 entry masks read");
        idle("R11 no trap after entry");
        // R3 remaining codes
        step(0, 0, 0, 0, 1, 32'h0000_9002, 0, 0, 0, 0, "R5 reload");
        step(1, 3'd3, 32'h0000_6000, 0, 0, 0, 0, 0, 0, 0, "R3 decrementer");
        step(0, 0, 0, 0, 1, 32'h0000_9002, 0, 0, 0, 0, "R5 reload2");
        step(1, 3'd7, 32'h0000_7000, 0, 0, 0, 0, 0, 0, 0, "R3 kind7");
        step(1, 3'd5, 32'h0000_7100, 0, 0, 0, 0, 0, 0, 0, "R2 nested entry");
        idle("R2 hold");
        idle("end");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got hung exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule